// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a synchronous RAM with two independent ports, A and B. Each port has its own clock, enable, write select, read-data gate, address, byte enables and data buses. Either port can read or write any word at any time. A read returns its data one clock edge after it is issued. If both ports write the same word in the same cycle, the stored result is undefined.

The two top word addresses also serve as message slots between the ports. The very top word belongs to port B, and the word just below it belongs to port A. Each port has an active-low interrupt output. It drops when the opposite port writes that port's slot with at least one byte enabled. It rises again when the owning port reads its own slot. Set and clear events cross between the clock domains through toggle handshakes, and each port keeps a single flag in its own domain.

An asynchronous active-low reset clears both flags and the read registers. It does not touch the array contents.

Top module: `mbox_dpram`

## Requirements
- R1: Every word reads as zero before its first write. A write updates only the 9-bit lanes whose byte-enable bit is 1: bit i covers data bits 9i+8..9i. The written value can be read from either port, and it appears on the read data after the clock edge that samples the read.
- R2: Port B's slot is address 2^ADDR_W-1 and port A's slot is address 2^ADDR_W-2. Both slots also hold data like any other word.
- R3: When port A writes address 2^ADDR_W-1 with a nonzero byte enable, b_irq_n goes low within 4 B-clock cycles. When port B writes address 2^ADDR_W-2 the same way, a_irq_n goes low within 4 A-clock cycles.
- R4: A write to the peer's slot with all byte enables zero sets no interrupt and leaves the stored word unchanged.
- R5: A read by the owning port of its own slot returns that port's interrupt output high on the clock edge that samples the read.
- R6: A read by a port of the peer's slot leaves the peer's interrupt output unchanged.
- R7: A write by a port to its own slot sets neither interrupt.
- R8: When a set event and an owner read of the slot land on the same owner clock edge, the set wins and the interrupt stays low.
- R9: While rst_n is low, both interrupt outputs are high and both read-data outputs are zero, without waiting for any clock.
- R10: When a port's output gate (x_oe) is 0, that port's read data reads zero. The gate has no effect on interrupt set or clear, and on the next edge with the gate at 1 the port shows its registered read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_oe | input | 1 | Port A read-data gate |
| a_addr | input | ADDR_W | Port A word address |
| a_be | input | BE_W | Port A byte enables |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data |
| a_irq_n | output | 1 | Port A mailbox interrupt, active low |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_oe | input | 1 | Port B read-data gate |
| b_addr | input | ADDR_W | Port B word address |
| b_be | input | BE_W | Port B byte enables |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_irq_n | output | 1 | Port B mailbox interrupt, active low |

## Verification
A set event that has crossed from the peer domain can reach the owner on the same edge as the owner's read of its slot. The bench provokes this by timing port B's read of its slot to land exactly three B-clock edges after port A's slot write, which is when the synchronized set pulse arrives. It judges the result by b_irq_n staying low after that edge, and by a second, lone read then raising it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Receiving side of a toggle handshake plus the owner's interrupt flag
    typedef struct packed {
        logic [1:0] sync;   // two-stage synchronizer of the peer toggle
        logic       last;   // previous synchronized value, for edge detect
        logic       flag;   // 1 = interrupt pending
    } irq_sync_t;

endpackage

// File: rtl/mbox_bank.sv
// One write bank of an XOR-coded dual-write array: written only from its own
// clock, read combinationally at both ports' addresses.
module mbox_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 72,
    parameter int BE_W   = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [DATA_W-1:0] rdata0,
    output logic [DATA_W-1:0] rdata1
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / BE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Power-up contents: all zero, so XOR of both banks is zero
    initial begin
        for (int w = 0; w < DEPTH; w++) mem_q[w] = '0;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < BE_W; l++) begin
                if (be[l]) mem_q[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata0 = mem_q[raddr0];
    assign rdata1 = mem_q[raddr1];

endmodule

// File: rtl/mbox_side.sv
// Per-port logic: read register, XOR write coding, outgoing set toggle and
// the port's own interrupt flag.
module mbox_side #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 72,
    parameter int BE_W   = 8,
    parameter bit SIDE_B = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] own_q,
    input  logic [DATA_W-1:0] peer_q,
    input  logic              tgl_in,
    output logic              bank_we,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              tgl_out,
    output logic              irq_set,
    output logic              irq_clr,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);
    import mbox_pkg::*;

    localparam logic [ADDR_W-1:0] SLOT_HI   = '1;
    localparam logic [ADDR_W-1:0] SLOT_LO   = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] OWN_SLOT  = SIDE_B ? SLOT_HI : SLOT_LO;
    localparam logic [ADDR_W-1:0] PEER_SLOT = SIDE_B ? SLOT_LO : SLOT_HI;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              tgl;
        irq_sync_t         irq;
    } side_state_t;

    side_state_t st_d, st_q;
    logic        wr_c, rd_c, peer_hit_c, set_c, clr_c;

    always_comb begin
        st_d       = st_q;
        wr_c       = en && we;
        rd_c       = en && !we;
        peer_hit_c = wr_c && (addr == PEER_SLOT) && (|be);
        set_c      = st_q.irq.sync[1] ^ st_q.irq.last;
        clr_c      = rd_c && (addr == OWN_SLOT);

        if (rd_c) st_d.rdata = own_q ^ peer_q;
        st_d.tgl = st_q.tgl ^ peer_hit_c;

        st_d.irq.sync = {st_q.irq.sync[0], tgl_in};
        st_d.irq.last = st_q.irq.sync[1];
        if (set_c)      st_d.irq.flag = 1'b1;
        else if (clr_c) st_d.irq.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_we    = wr_c;
    assign bank_wdata = wdata ^ peer_q;
    assign tgl_out    = st_q.tgl;
    assign irq_set    = set_c;
    assign irq_clr    = clr_c;
    assign rdata      = oe ? st_q.rdata : '0;
    assign irq_n      = ~st_q.irq.flag;

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 72,
    parameter int BE_W   = 8
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_oe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [BE_W-1:0]   a_be,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_clk,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_oe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [BE_W-1:0]   b_be,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);
    localparam int N_PORT = 2;

    logic [N_PORT-1:0]                     clk_s, en_s, we_s, oe_s;
    logic [N_PORT-1:0][ADDR_W-1:0]         addr_s;
    logic [N_PORT-1:0][BE_W-1:0]           be_s;
    logic [N_PORT-1:0][DATA_W-1:0]         wdata_s, rdata_s, bank_wdata_s;
    logic [N_PORT-1:0]                     bank_we_s, tgl_s, irq_set_s, irq_clr_s, irq_n_s;
    // bank_q[bank][port address]
    logic [N_PORT-1:0][N_PORT-1:0][DATA_W-1:0] bank_q;

    assign clk_s   = {b_clk, a_clk};
    assign en_s    = {b_en, a_en};
    assign we_s    = {b_we, a_we};
    assign oe_s    = {b_oe, a_oe};
    assign addr_s  = {b_addr, a_addr};
    assign be_s    = {b_be, a_be};
    assign wdata_s = {b_wdata, a_wdata};

    for (genvar s = 0; s < N_PORT; s++) begin : g_side
        mbox_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_bank (
            .clk    (clk_s[s]),
            .we     (bank_we_s[s]),
            .be     (be_s[s]),
            .waddr  (addr_s[s]),
            .wdata  (bank_wdata_s[s]),
            .raddr0 (addr_s[0]),
            .raddr1 (addr_s[1]),
            .rdata0 (bank_q[s][0]),
            .rdata1 (bank_q[s][1])
        );

        mbox_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .SIDE_B(s == 1)) u_side (
            .clk        (clk_s[s]),
            .rst_n      (rst_n),
            .en         (en_s[s]),
            .we         (we_s[s]),
            .oe         (oe_s[s]),
            .addr       (addr_s[s]),
            .be         (be_s[s]),
            .wdata      (wdata_s[s]),
            .own_q      (bank_q[s][s]),
            .peer_q     (bank_q[1-s][s]),
            .tgl_in     (tgl_s[1-s]),
            .bank_we    (bank_we_s[s]),
            .bank_wdata (bank_wdata_s[s]),
            .tgl_out    (tgl_s[s]),
            .irq_set    (irq_set_s[s]),
            .irq_clr    (irq_clr_s[s]),
            .rdata      (rdata_s[s]),
            .irq_n      (irq_n_s[s])
        );
    end

    assign a_rdata = rdata_s[0];
    assign b_rdata = rdata_s[1];
    assign a_irq_n = irq_n_s[0];
    assign b_irq_n = irq_n_s[1];

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 72,
    parameter int BE_W   = 8
) (
    input logic              rst_n,
    input logic              a_clk,
    input logic              a_en,
    input logic              a_we,
    input logic              a_oe,
    input logic [ADDR_W-1:0] a_addr,
    input logic [BE_W-1:0]   a_be,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_irq_n,
    input logic              b_clk,
    input logic              b_en,
    input logic              b_we,
    input logic              b_oe,
    input logic [ADDR_W-1:0] b_addr,
    input logic [BE_W-1:0]   b_be,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_irq_n,
    input logic [1:0]        tgl_s,
    input logic [1:0]        irq_set_s,
    input logic [1:0]        irq_clr_s
);
    localparam logic [ADDR_W-1:0] SLOT_HI = '1;
    localparam logic [ADDR_W-1:0] SLOT_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

    // R8: an arriving set leaves the flag set, whatever the owner reads
    p_set_a_r8: assert property (@(posedge a_clk) disable iff (!rst_n)
        irq_set_s[0] |=> !a_irq_n);
    p_set_b_r3: assert property (@(posedge b_clk) disable iff (!rst_n)
        irq_set_s[1] |=> !b_irq_n);

    // R5 / R10: owner read clears regardless of the output gate
    p_clr_a_r5: assert property (@(posedge a_clk) disable iff (!rst_n)
        (irq_clr_s[0] && !irq_set_s[0]) |=> a_irq_n);
    p_clr_b_r10: assert property (@(posedge b_clk) disable iff (!rst_n)
        (irq_clr_s[1] && !irq_set_s[1]) |=> b_irq_n);

    // R6: without a set or an owner read the interrupt holds
    p_hold_a_r6: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!irq_set_s[0] && !irq_clr_s[0]) |=> $stable(a_irq_n));
    p_hold_b_r6: assert property (@(posedge b_clk) disable iff (!rst_n)
        (!irq_set_s[1] && !irq_clr_s[1]) |=> $stable(b_irq_n));

    // R7: writes to one's own slot send no set event
    p_own_a_r7: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_en && a_we && a_addr == SLOT_LO) |=> $stable(tgl_s[0]));
    p_own_b_r7: assert property (@(posedge b_clk) disable iff (!rst_n)
        (b_en && b_we && b_addr == SLOT_HI) |=> $stable(tgl_s[1]));

    // R4: a write with no byte enabled sends no set event
    p_nobe_a_r4: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_en && a_we && a_be == '0) |=> $stable(tgl_s[0]));
    p_nobe_b_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
        (b_en && b_we && b_be == '0) |=> $stable(tgl_s[1]));

    // R10: gated read data is zero
    p_gate_a_r10: assert property (@(negedge a_clk) disable iff (!rst_n)
        !a_oe |-> a_rdata == '0);
    p_gate_b_r10: assert property (@(negedge b_clk) disable iff (!rst_n)
        !b_oe |-> b_rdata == '0);

    // R9: reset state visible at the outputs
    always @(negedge a_clk) begin
        if (!rst_n) begin
            p_rst_r9: assert (a_irq_n && b_irq_n && a_rdata == '0 && b_rdata == '0);
        end
    end

endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
    .rst_n     (rst_n),
    .a_clk     (a_clk),
    .a_en      (a_en),
    .a_we      (a_we),
    .a_oe      (a_oe),
    .a_addr    (a_addr),
    .a_be      (a_be),
    .a_rdata   (a_rdata),
    .a_irq_n   (a_irq_n),
    .b_clk     (b_clk),
    .b_en      (b_en),
    .b_we      (b_we),
    .b_oe      (b_oe),
    .b_addr    (b_addr),
    .b_be      (b_be),
    .b_rdata   (b_rdata),
    .b_irq_n   (b_irq_n),
    .tgl_s     (tgl_s),
    .irq_set_s (irq_set_s),
    .irq_clr_s (irq_clr_s)
);

// File: tb/mbox_dpram_tb.sv
`timescale 1ns/1ps
module mbox_dpram_tb;
    localparam int AW = 8;
    localparam int DW = 72;
    localparam int BW = 8;
    localparam int LW = DW / BW;
    localparam logic [AW-1:0] HI = '1;
    localparam logic [AW-1:0] LO = {{(AW-1){1'b1}}, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_we = 0, a_oe = 1, b_en = 0, b_we = 0, b_oe = 1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [BW-1:0] a_be = '0, b_be = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_irq_n, b_irq_n;

    logic [DW-1:0] ref_mem [1 << AW];
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .BE_W(BW)) u_dut (
        .rst_n(rst_n),
        .a_clk(clk), .a_en(a_en), .a_we(a_we), .a_oe(a_oe), .a_addr(a_addr),
        .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_clk(clk), .b_en(b_en), .b_we(b_we), .b_oe(b_oe), .b_addr(b_addr),
        .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return {9{8'(i * 29 + 7)}} ^ (DW'(i) * 72'h01_0203_0507_0B0D_1113);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write from port s (0 = A, 1 = B); returns at the negedge after the write edge
    task automatic wr(input bit s, input logic [AW-1:0] ad, input logic [BW-1:0] be,
                      input logic [DW-1:0] d);
        @(negedge clk);
        if (s) begin b_en = 1; b_we = 1; b_addr = ad; b_be = be; b_wdata = d; end
        else   begin a_en = 1; a_we = 1; a_addr = ad; a_be = be; a_wdata = d; end
        @(negedge clk);
        if (s) begin b_en = 0; b_we = 0; end
        else   begin a_en = 0; a_we = 0; end
        for (int l = 0; l < BW; l++)
            if (be[l]) ref_mem[ad][l*LW +: LW] = d[l*LW +: LW];
    endtask

    // Read from port s; returns at the negedge after the sampling edge
    task automatic rd(input bit s, input logic [AW-1:0] ad, output logic [DW-1:0] q);
        @(negedge clk);
        if (s) begin b_en = 1; b_we = 0; b_addr = ad; end
        else   begin a_en = 1; a_we = 0; a_addr = ad; end
        @(negedge clk);
        q = s ? b_rdata : a_rdata;
        if (s) b_en = 0; else a_en = 0;
    endtask

    task automatic t_reset();
        chk("R9 reset a_irq_n", DW'(a_irq_n), DW'(1));
        chk("R9 reset b_irq_n", DW'(b_irq_n), DW'(1));
        chk("R9 reset a_rdata", a_rdata, '0);
        chk("R9 reset b_rdata", b_rdata, '0);
    endtask

    task automatic t_rw_r1();
        logic [DW-1:0] q;
        rd(1, 8'd200, q);
        chk("R1 unwritten word zero", q, '0);
        for (int i = 0; i < 6; i++) begin
            wr(i[0], AW'(i * 17 + 3), 8'hFF, pat(i));
            rd(!i[0], AW'(i * 17 + 3), q);
            chk("R1 cross-port full write", q, ref_mem[AW'(i * 17 + 3)]);
        end
        wr(1, 8'd3, 8'h0F, pat(40));
        rd(0, 8'd3, q);
        chk("R1 low lanes from B", q, ref_mem[3]);
        wr(0, 8'd3, 8'hA0, pat(41));
        rd(1, 8'd3, q);
        chk("R1 mixed lanes from A", q, ref_mem[3]);
        rd(0, 8'd3, q);
        chk("R1 same-port readback", q, ref_mem[3]);
    endtask

    task automatic t_mailbox();
        logic [DW-1:0] q;
        wr(0, HI, 8'hFF, pat(50));
        idle(4);
        chk("R3 A write sets b_irq_n", DW'(b_irq_n), DW'(0));
        chk("R3 a_irq_n untouched", DW'(a_irq_n), DW'(1));
        rd(0, HI, q);
        chk("R2 slot HI holds data", q, ref_mem[HI]);
        chk("R6 peer read keeps b_irq_n", DW'(b_irq_n), DW'(0));
        b_oe = 0;
        rd(1, HI, q);
        chk("R5 owner read clears b_irq_n (gate low, R10)", DW'(b_irq_n), DW'(1));
        chk("R10 gated read data zero", q, '0);
        b_oe = 1;
        #0.1;
        chk("R10 ungated shows registered data", b_rdata, ref_mem[HI]);
        wr(1, LO, 8'h01, pat(51));
        idle(4);
        chk("R3 B write sets a_irq_n", DW'(a_irq_n), DW'(0));
        rd(0, LO, q);
        chk("R5 owner read clears a_irq_n", DW'(a_irq_n), DW'(1));
        chk("R2 slot LO holds data", q, ref_mem[LO]);
    endtask

    task automatic t_nobe_r4();
        logic [DW-1:0] q;
        wr(0, HI, 8'h00, pat(60));
        wr(1, LO, 8'h00, pat(61));
        idle(5);
        chk("R4 no-lane write keeps b_irq_n", DW'(b_irq_n), DW'(1));
        chk("R4 no-lane write keeps a_irq_n", DW'(a_irq_n), DW'(1));
        rd(1, HI, q);
        chk("R4 word unchanged", q, ref_mem[HI]);
    endtask

    task automatic t_own_r7();
        wr(1, HI, 8'hFF, pat(70));
        wr(0, LO, 8'hFF, pat(71));
        idle(5);
        chk("R7 own-slot writes leave a_irq_n", DW'(a_irq_n), DW'(1));
        chk("R7 own-slot writes leave b_irq_n", DW'(b_irq_n), DW'(1));
    endtask

    task automatic t_set_wins_r8();
        logic [DW-1:0] q;
        wr(0, HI, 8'h80, pat(80));
        idle(1);
        rd(1, HI, q);   // sampled on the third B edge after the write edge
        chk("R8 set beats coincident clear", DW'(b_irq_n), DW'(0));
        rd(1, HI, q);
        chk("R8 later read clears", DW'(b_irq_n), DW'(1));
    endtask

    task automatic t_async_rst_r9();
        logic [DW-1:0] q;
        rd(0, 8'd3, q);
        chk("R9 precondition data", q, ref_mem[3]);
        wr(1, LO, 8'hFF, pat(90));
        idle(4);
        chk("R9 precondition a_irq_n", DW'(a_irq_n), DW'(0));
        #1 rst_n = 0;
        #0.5;
        chk("R9 async reset a_irq_n", DW'(a_irq_n), DW'(1));
        chk("R9 async reset a_rdata", a_rdata, '0);
        @(negedge clk);
        rst_n = 1;
        idle(1);
    endtask

    initial begin
        for (int w = 0; w < (1 << AW); w++) ref_mem[w] = '0;
        idle(3);
        t_reset();
        rst_n = 1;
        idle(2);
        t_rw_r1();
        t_mailbox();
        t_nobe_r4();
        t_own_r7();
        t_set_wins_r8();
        t_async_rst_r9();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule